// File: doc/BRIEF.md
# Link Pulse Generator and Integrity Monitor

This block keeps a twisted-pair link alive and watches whether the far end is still there. While the local transmitter is quiet, it sends a short link pulse once per period. A transmission clears the period timer. At the same time it watches for pulses or receive activity from the remote end. If the remote end goes silent for longer than a set window, the block drops its enable, which gates the transmit, receive and collision paths. It also drops a good-link status that can drive an LED.

After a failure the link only comes back once the remote end has sent a set number of link pulses in a row, each within one window of the one before it. A test input bypasses the whole check, so the link reads as good and the data path stays enabled. All intervals are counted in clock cycles. With a 100 MHz clock the defaults give a 10-cycle pulse every 16 ms and a 100 ms silence window. A simulation can shrink these values.

Top module: `link_keeper`

## Requirements
- R1: While `tx_active` is low, `link_pulse` rises once every PERIOD_CYC cycles and stays high for exactly PULSE_CYC cycles.
- R2: `link_pulse` is low in every cycle in which `tx_active` is high, and no pulse is emitted while transmission continues.
- R3: The first pulse after a transmission rises PERIOD_CYC cycles after the last clock edge that sampled `tx_active` high.
- R4: After reset the link is in the failed state: `link_good`, `func_en` and `link_pulse` are all 0.
- R5: In the good state, `rx_pulse` or `rx_active` sampled high restarts the silence window. The link fails (`link_good` falls) FAIL_WIN_CYC edges after the last edge that saw activity.
- R6: In the failed state, `rx_active` has no effect. The link is restored on the edge that samples the RESTORE_PULSES-th consecutive `rx_pulse`, where each pulse follows the one before within FAIL_WIN_CYC edges. A longer gap discards the run, and the next pulse counts as the first.
- R7: `lt_disable` high forces `link_good` and `func_en` to 1 in the same cycle. When it is released, a fresh silence window starts from the last edge that saw it high.
- R8: `func_en` always equals `link_good`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_active | input | 1 | Local transmitter is sending data |
| rx_pulse | input | 1 | One-cycle strobe for a valid remote link pulse |
| rx_active | input | 1 | Receive data is present |
| lt_disable | input | 1 | Bypass the integrity check |
| link_pulse | output | 1 | Link pulse to the transmit driver |
| link_good | output | 1 | Link status, suited to an LED |
| func_en | output | 1 | Enable for transmit, receive and collision functions |

## Verification
Each result falls due at a fixed number of edges after its stimulus. A pulse rises PERIOD_CYC edges after the last transmit-active edge, or after the previous rise. A failure is due FAIL_WIN_CYC edges after the last activity, or after `lt_disable` is released. A restore comes on the edge that samples the final remote pulse. Forcing by `lt_disable` shows in the same cycle. The driver records the edge number of each input change, because inputs are applied just after a falling edge. It pushes each expected transition into a queue tagged with its predicted edge. The monitor samples on falling edges and pops an entry for every transition it sees, comparing kind and edge. Any transition it sees with nothing queued, and any entry left in the queue at the end, counts as a failure.

// File: rtl/lk_pkg.sv
package lk_pkg;
   typedef enum logic {
      LINK_DOWN = 1'b0,
      LINK_UP   = 1'b1
   } link_state_e;
endpackage

// File: rtl/lk_pulse_gen.sv
module lk_pulse_gen #(
   parameter int PERIOD_CYC = 1_600_000,
   parameter int PULSE_CYC  = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_active,
   output logic link_pulse
);
   localparam int PER_W = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;
   localparam int WID_W = $clog2(PULSE_CYC + 1);
   localparam logic [PER_W-1:0] PER_LAST = PER_W'(PERIOD_CYC - 1);

   generate
      if (PULSE_CYC < 1 || PULSE_CYC >= PERIOD_CYC) begin : g_bad_width
         $error("lk_pulse_gen: PULSE_CYC must lie in 1..PERIOD_CYC-1");
      end
   endgenerate

   logic [PER_W-1:0] per_cnt;
   logic [WID_W-1:0] wid_left;
   logic             pulse_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         per_cnt  <= '0;
         wid_left <= '0;
         pulse_q  <= 1'b0;
      end else if (tx_active) begin
         per_cnt  <= '0;
         wid_left <= '0;
         pulse_q  <= 1'b0;
      end else begin
         per_cnt <= (per_cnt == PER_LAST) ? '0 : per_cnt + 1'b1;
         if (per_cnt == PER_LAST) begin
            pulse_q  <= 1'b1;
            wid_left <= WID_W'(PULSE_CYC - 1);
         end else if (pulse_q) begin
            if (wid_left == '0) pulse_q <= 1'b0;
            else                wid_left <= wid_left - 1'b1;
         end
      end
   end

   assign link_pulse = pulse_q & ~tx_active;

   AST_PULSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q && (wid_left != '0) && !tx_active |=> pulse_q); // R1
   AST_PERIOD_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_active && (per_cnt == PER_LAST) |=> pulse_q && (per_cnt == '0)); // R3
   AST_TX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      tx_active |=> !pulse_q && (per_cnt == '0)); // R2
   AST_WIDTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |-> (wid_left < WID_W'(PULSE_CYC))); // R1
endmodule

// File: rtl/lk_integrity.sv
module lk_integrity
   import lk_pkg::*;
#(
   parameter int FAIL_WIN_CYC   = 10_000_000,
   parameter int RESTORE_PULSES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rx_pulse,
   input  logic        rx_active,
   input  logic        lt_disable,
   output link_state_e state_o
);
   localparam int SIL_W = $clog2(FAIL_WIN_CYC);
   localparam logic [SIL_W-1:0] SIL_LAST = SIL_W'(FAIL_WIN_CYC - 1);

   generate
      if (FAIL_WIN_CYC < 2) begin : g_bad_win
         $error("lk_integrity: FAIL_WIN_CYC must be at least 2");
      end
      if (RESTORE_PULSES < 1) begin : g_bad_restore
         $error("lk_integrity: RESTORE_PULSES must be at least 1");
      end
   endgenerate

   link_state_e      state;
   logic [SIL_W-1:0] sil;
   logic             in_fail;
   logic             restore_hit;
   logic             run_active;
   logic             sil_expire;

   assign in_fail    = (state == LINK_DOWN) && !lt_disable;
   assign sil_expire = in_fail && run_active && !rx_pulse && (sil == SIL_LAST);

   generate
      if (RESTORE_PULSES == 1) begin : g_single
         assign restore_hit = rx_pulse;
         assign run_active  = 1'b0;
      end else begin : g_multi
         localparam int CNT_W = $clog2(RESTORE_PULSES);
         logic [CNT_W-1:0] run_cnt;
         assign restore_hit = rx_pulse && (run_cnt == CNT_W'(RESTORE_PULSES - 1));
         assign run_active  = (run_cnt != '0);
         always_ff @(posedge clk) begin
            if (!rst_n || !in_fail)  run_cnt <= '0;
            else if (restore_hit)    run_cnt <= '0;
            else if (rx_pulse)       run_cnt <= run_cnt + 1'b1;
            else if (sil_expire)     run_cnt <= '0;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= LINK_DOWN;
         sil   <= '0;
      end else if (lt_disable) begin
         state <= LINK_UP;
         sil   <= '0;
      end else if (state == LINK_UP) begin
         if (rx_pulse || rx_active) begin
            sil <= '0;
         end else if (sil == SIL_LAST) begin
            state <= LINK_DOWN;
            sil   <= '0;
         end else begin
            sil <= sil + 1'b1;
         end
      end else begin
         if (restore_hit) begin
            state <= LINK_UP;
            sil   <= '0;
         end else if (rx_pulse || !run_active || sil == SIL_LAST) begin
            sil <= '0;
         end else begin
            sil <= sil + 1'b1;
         end
      end
   end

   assign state_o = state;

   AST_SIL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      sil <= SIL_LAST); // R5
   AST_ACT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == LINK_UP) && !lt_disable && (rx_pulse || rx_active)
      |=> (state == LINK_UP) && (sil == '0)); // R5
   AST_NO_RESTORE_WITHOUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == LINK_DOWN) && !lt_disable && !rx_pulse |=> (state == LINK_DOWN)); // R6
   AST_BYPASS_UP: assert property (@(posedge clk) disable iff (!rst_n)
      lt_disable |=> (state == LINK_UP) && (sil == '0)); // R7
endmodule

// File: rtl/link_keeper.sv
module link_keeper
   import lk_pkg::*;
#(
   parameter int PERIOD_CYC     = 1_600_000,
   parameter int PULSE_CYC      = 10,
   parameter int FAIL_WIN_CYC   = 10_000_000,
   parameter int RESTORE_PULSES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_active,
   input  logic rx_pulse,
   input  logic rx_active,
   input  logic lt_disable,
   output logic link_pulse,
   output logic link_good,
   output logic func_en
);
   link_state_e mon_state;

   lk_pulse_gen #(
      .PERIOD_CYC (PERIOD_CYC),
      .PULSE_CYC  (PULSE_CYC)
   ) u_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .tx_active  (tx_active),
      .link_pulse (link_pulse)
   );

   lk_integrity #(
      .FAIL_WIN_CYC   (FAIL_WIN_CYC),
      .RESTORE_PULSES (RESTORE_PULSES)
   ) u_mon (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_pulse   (rx_pulse),
      .rx_active  (rx_active),
      .lt_disable (lt_disable),
      .state_o    (mon_state)
   );

   assign link_good = (mon_state == LINK_UP) || lt_disable;
   assign func_en   = link_good;
endmodule

// File: tb/sim_link_keeper.sv
module sim_link_keeper;
   localparam int PER  = 40;
   localparam int PW   = 4;
   localparam int WIN  = 100;
   localparam int REST = 2;
   localparam int K_PULSE = 0;
   localparam int K_UP    = 1;
   localparam int K_DOWN  = 2;

   typedef struct {
      int kind;
      int cyc;
      string req;
   } ev_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_active = 1'b1;
   logic rx_pulse = 1'b0;
   logic rx_active = 1'b0;
   logic lt_disable = 1'b0;
   logic link_pulse, link_good, func_en;

   int cyc = 0;
   int n_chk = 0;
   int n_fail = 0;
   ev_t exp_q[$];
   bit live = 1'b0;
   bit done = 1'b0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   link_keeper #(
      .PERIOD_CYC(PER), .PULSE_CYC(PW), .FAIL_WIN_CYC(WIN), .RESTORE_PULSES(REST)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .tx_active(tx_active), .rx_pulse(rx_pulse),
      .rx_active(rx_active), .lt_disable(lt_disable),
      .link_pulse(link_pulse), .link_good(link_good), .func_en(func_en)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic expect_ev(input int kind, input int at, input string req);
      ev_t e;
      e.kind = kind; e.cyc = at; e.req = req;
      exp_q.push_back(e);
   endtask

   task automatic step_to(input int t);
      do @(negedge clk); while (cyc < t);
      #1;
   endtask

   task automatic send_pulse();
      int k;
      k = cyc;
      rx_pulse = 1'b1;
      step_to(k + 1);
      rx_pulse = 1'b0;
   endtask

   task automatic observe(input int kind);
      ev_t e;
      if (exp_q.size() == 0) begin
         chk(1'b0, "R2/R5/R6 unexpected transition", kind, -1);
      end else begin
         e = exp_q.pop_front();
         chk(e.kind == kind, e.req, kind, e.kind);
         chk(e.cyc == cyc, e.req, cyc, e.cyc);
      end
   endtask

   // monitor: samples on falling edges, scoreboard compare
   logic p_prev, g_prev;
   int   hi_len;
   always @(negedge clk) begin
      if (live) begin
         chk(func_en == link_good, "R8", int'(func_en), int'(link_good));
         if (link_pulse && !p_prev) begin
            observe(K_PULSE);
            hi_len = 1;
         end else if (link_pulse) begin
            hi_len++;
         end else if (p_prev) begin
            chk(hi_len == PW, "R1 width", hi_len, PW);
         end
         if (link_good && !g_prev) observe(K_UP);
         if (!link_good && g_prev) observe(K_DOWN);
      end
      p_prev = link_pulse;
      g_prev = link_good;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int n, m, t, c, d, e;
      repeat (5) @(negedge clk);
      #1 rst_n = 1'b1;
      step_to(cyc + 2);
      chk(link_pulse == 1'b0, "R4 pulse", int'(link_pulse), 0);
      chk(link_good == 1'b0, "R4 good", int'(link_good), 0);
      chk(func_en == 1'b0, "R4 enable", int'(func_en), 0);
      live = 1'b1;

      // R1: free-running pulses while idle
      n = cyc;
      tx_active = 1'b0;
      expect_ev(K_PULSE, n + PER, "R1 period");
      expect_ev(K_PULSE, n + 2*PER, "R1 period");
      expect_ev(K_PULSE, n + 3*PER, "R1 period");
      step_to(n + 3*PER + PW + 2);
      tx_active = 1'b1;
      // R2: long transmit, no pulse expected
      step_to(cyc + 3*PER);
      chk(link_pulse == 1'b0, "R2 quiet", int'(link_pulse), 0);
      chk(exp_q.size() == 0, "R2 queue", exp_q.size(), 0);
      // R3: first pulse one full period after transmit ends
      m = cyc;
      tx_active = 1'b0;
      expect_ev(K_PULSE, m + PER, "R3 first pulse");
      step_to(m + PER + PW + 1);
      tx_active = 1'b1;
      step_to(cyc + 5);
      chk(exp_q.size() == 0, "R3 queue", exp_q.size(), 0);

      // R6: restore from reset-failed state with two pulses
      send_pulse();
      step_to(cyc + 18);
      t = cyc + 1;
      expect_ev(K_UP, t, "R6 restore");
      send_pulse();
      // R5: receive activity keeps the link up
      step_to(t + 9);
      rx_active = 1'b1;
      step_to(t + 150);
      chk(link_good == 1'b1, "R5 held by rx_active", int'(link_good), 1);
      step_to(t + 159);
      rx_active = 1'b0;
      expect_ev(K_DOWN, t + 159 + WIN, "R5 timeout");
      step_to(t + 159 + WIN + 5);
      chk(link_good == 1'b0, "R5 failed", int'(link_good), 0);
      chk(func_en == 1'b0, "R8 disabled path", int'(func_en), 0);

      // R6: rx_active ignored while failed
      rx_active = 1'b1;
      step_to(cyc + 50);
      rx_active = 1'b0;
      chk(link_good == 1'b0, "R6 rx_active ignored", int'(link_good), 0);
      // R6: gap longer than the window discards the run
      send_pulse();
      step_to(cyc + WIN + 4);
      send_pulse();
      step_to(cyc + 5);
      chk(link_good == 1'b0, "R6 late pulse", int'(link_good), 0);
      step_to(cyc + 24);
      t = cyc + 1;
      expect_ev(K_UP, t, "R6 restore after gap");
      send_pulse();

      // R7: bypass keeps the link up through silence
      step_to(t + 50);
      lt_disable = 1'b1;
      step_to(cyc + 200);
      chk(link_good == 1'b1, "R7 bypass good", int'(link_good), 1);
      chk(func_en == 1'b1, "R7 bypass enable", int'(func_en), 1);
      c = cyc;
      lt_disable = 1'b0;
      expect_ev(K_DOWN, c + WIN, "R7 fresh window");
      step_to(c + WIN + 5);
      d = cyc;
      lt_disable = 1'b1;
      expect_ev(K_UP, d + 1, "R7 forced up");
      step_to(d + 10);
      chk(func_en == 1'b1, "R7 forced enable", int'(func_en), 1);
      e = cyc;
      lt_disable = 1'b0;
      expect_ev(K_DOWN, e + WIN, "R7 release window");
      step_to(e + WIN + 10);

      chk(exp_q.size() == 0, "R5/R7 missing events", exp_q.size(), 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule